// File: doc/BRIEF.md
# Single-Outstanding DMA Transaction Controller

This block sits between a local DMA requester and a memory-directory network. The requester offers load or store requests over a valid/ready handshake. Each request carries a physical address, a length and a data block. The controller turns each legal request into a read-type or write-type network message and holds that message in a delay slot for a fixed number of cycles. It then presents the message on the network side until the network takes it.

After the message is sent, the controller waits for the matching response. A data response completes a load and returns its data block to the requester. An acknowledgement completes a store and raises a completion strobe. Only one transaction is ever in flight. A new request is stalled until the previous one has completed and its message has left the delay slot. Responses that do not fit the current wait state stay unconsumed. Request or response type codes outside the legal set raise a one-cycle error flag.

Top module: `dma_xact_ctrl`

## Requirements
- R1: During and right after reset the controller is idle: `req_ready`=1, and `net_valid`, `rd_valid`, `wr_done` and `err` are all 0.
- R2: An idle controller accepts a load (`req_kind`=2'b01). It then stops accepting requests, and its network message has `net_type`=2'b01 (read).
- R3: An idle controller accepts a store (`req_kind`=2'b10). It then stops accepting requests, and its network message has `net_type`=2'b10 (write).
- R4: The network message carries the accepted request's `req_paddr`, `req_len` and `req_data` unchanged. `net_class` is always 2'b01 (control-sized).
- R5: `net_valid` first reads high exactly DELAY (default 6) rising edges after the edge that accepted the request.
- R6: While `net_valid`=1 and `net_ready`=0, the message stays valid and its fields stay stable. It is removed on the edge where `net_ready`=1.
- R7: `req_ready` is 0 while a transaction is outstanding or its message is still undelivered. A held request is accepted once both have cleared.
- R8: While waiting for a load, a response with `rsp_kind`=2'b01 (data) is consumed. `rd_valid` pulses for one cycle after that edge with `rd_data`=`rsp_data`, and the controller becomes idle.
- R9: While waiting for a store, a response with `rsp_kind`=2'b10 (acknowledge) is consumed. `wr_done` pulses for one cycle after that edge, and the controller becomes idle.
- R10: A data or acknowledge response that does not match the current wait state is not consumed: `rsp_ready`=0. This includes any such response while the controller is idle. The state is unchanged.
- R11: A request with `req_kind` 2'b00 or 2'b11 is accepted and dropped. `err` pulses for one cycle, no message is produced, and the controller stays idle.
- R12: A response with `rsp_kind` 2'b00 or 2'b11 is consumed in any state. `err` pulses for one cycle, and the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 01 load, 10 store, others illegal |
| req_paddr | input | AW | Physical address |
| req_len | input | LW | Transfer length |
| req_data | input | DW | Data block |
| net_valid | output | 1 | Network message present |
| net_ready | input | 1 | Network takes the message |
| net_type | output | 2 | 01 read, 10 write |
| net_class | output | 2 | Message size class, 01 control |
| net_paddr | output | AW | Copied physical address |
| net_len | output | LW | Copied length |
| net_data | output | DW | Copied data block |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response consumed this cycle |
| rsp_kind | input | 2 | 01 data, 10 acknowledge, others illegal |
| rsp_data | input | DW | Response data block |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DW | Returned read data |
| wr_done | output | 1 | One-cycle write-completion strobe |
| err | output | 1 | One-cycle illegal-type flag |

## Verification
The hardest situation to reach from the ports is a second request waiting behind a message that has finished its delay but is blocked by `net_ready`. The same window should also see an early or mismatched response arrive. The bench produces this by holding `net_ready` low for several cycles past the delay. Meanwhile a forked process holds a waiting request and another offers wrong-kind responses. A long random phase then mixes request kinds, response kinds and network back-pressure, so that responses also land before the message has left the delay slot.

// File: rtl/dma_xact_pkg.sv
package dma_xact_pkg;

  typedef enum logic [1:0] {
    ST_READY   = 2'd0,
    ST_BUSY_RD = 2'd1,
    ST_BUSY_WR = 2'd2
  } xact_state_e;

  localparam logic [1:0] REQ_LOAD   = 2'b01;
  localparam logic [1:0] REQ_STORE  = 2'b10;
  localparam logic [1:0] RSP_DATA   = 2'b01;
  localparam logic [1:0] RSP_ACK    = 2'b10;
  localparam logic [1:0] MSG_DMA_RD = 2'b01;
  localparam logic [1:0] MSG_DMA_WR = 2'b10;
  localparam logic [1:0] CLS_CTRL   = 2'b01;

  // a type code is legal when exactly one of its two bits is set
  function automatic logic kind_known(logic [1:0] k);
    return k == 2'b01 || k == 2'b10;
  endfunction

  // responses of illegal type are always taken (and flagged); legal ones only when awaited
  function automatic logic rsp_consumable(xact_state_e s, logic [1:0] k);
    return !kind_known(k)
        || (s == ST_BUSY_RD && k == RSP_DATA)
        || (s == ST_BUSY_WR && k == RSP_ACK);
  endfunction

  function automatic logic [1:0] msg_type_for(logic [1:0] k);
    return (k == REQ_STORE) ? MSG_DMA_WR : MSG_DMA_RD;
  endfunction

endpackage

// File: rtl/dma_xact_fsm.sv
module dma_xact_fsm
  import dma_xact_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go_rd,
  input  logic        go_wr,
  input  logic        done_rd,
  input  logic        done_wr,
  output xact_state_e state
);

  xact_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_READY: begin
        if (go_rd)      nxt = ST_BUSY_RD;
        else if (go_wr) nxt = ST_BUSY_WR;
      end
      ST_BUSY_RD: if (done_rd) nxt = ST_READY;
      ST_BUSY_WR: if (done_wr) nxt = ST_READY;
      default:    nxt = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_READY;
    else        state <= nxt;
  end

endmodule

// File: rtl/dma_xact_delay.sv
module dma_xact_delay #(
  parameter int AW    = 32,
  parameter int LW    = 8,
  parameter int DW    = 64,
  parameter int DELAY = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    ld_type,
  input  logic [AW-1:0] ld_paddr,
  input  logic [LW-1:0] ld_len,
  input  logic [DW-1:0] ld_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [1:0]    out_type,
  output logic [AW-1:0] out_paddr,
  output logic [LW-1:0] out_len,
  output logic [DW-1:0] out_data,
  output logic          busy
);

  localparam int CW = (DELAY < 1) ? 1 : $clog2(DELAY + 1);

  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic          expired;

  assign expired   = (cnt_q == '0);
  assign out_valid = pend_q && expired;
  assign busy      = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      pend_q <= 1'b1;
      cnt_q  <= CW'(DELAY);
    end else if (pend_q) begin
      if (!expired)       cnt_q  <= cnt_q - CW'(1);
      else if (out_ready) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_type  <= '0;
      out_paddr <= '0;
      out_len   <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_type  <= ld_type;
      out_paddr <= ld_paddr;
      out_len   <= ld_len;
      out_data  <= ld_data;
    end
  end

endmodule

// File: rtl/dma_xact_ctrl.sv
module dma_xact_ctrl
  import dma_xact_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 8,
  parameter int DW    = 64,
  parameter int DELAY = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_paddr,
  input  logic [LW-1:0] req_len,
  input  logic [DW-1:0] req_data,
  output logic          net_valid,
  input  logic          net_ready,
  output logic [1:0]    net_type,
  output logic [1:0]    net_class,
  output logic [AW-1:0] net_paddr,
  output logic [LW-1:0] net_len,
  output logic [DW-1:0] net_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [1:0]    rsp_kind,
  input  logic [DW-1:0] rsp_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          wr_done,
  output logic          err
);

  xact_state_e cur_st;
  logic msg_busy;
  logic req_fire, req_good, go_rd, go_wr;
  logic rsp_fire, done_rd, done_wr, bad_rsp;

  assign req_ready = (cur_st == ST_READY) && !msg_busy;
  assign req_fire  = req_valid && req_ready;
  assign req_good  = kind_known(req_kind);
  assign go_rd     = req_fire && req_kind == REQ_LOAD;
  assign go_wr     = req_fire && req_kind == REQ_STORE;

  assign rsp_ready = rsp_consumable(cur_st, rsp_kind);
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign done_rd   = rsp_fire && rsp_kind == RSP_DATA;
  assign done_wr   = rsp_fire && rsp_kind == RSP_ACK;
  assign bad_rsp   = rsp_fire && !kind_known(rsp_kind);

  assign net_class = CLS_CTRL;

  dma_xact_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_rd   (go_rd),
    .go_wr   (go_wr),
    .done_rd (done_rd),
    .done_wr (done_wr),
    .state   (cur_st)
  );

  dma_xact_delay #(.AW(AW), .LW(LW), .DW(DW), .DELAY(DELAY)) u_dly (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (go_rd || go_wr),
    .ld_type   (msg_type_for(req_kind)),
    .ld_paddr  (req_paddr),
    .ld_len    (req_len),
    .ld_data   (req_data),
    .out_ready (net_ready),
    .out_valid (net_valid),
    .out_type  (net_type),
    .out_paddr (net_paddr),
    .out_len   (net_len),
    .out_data  (net_data),
    .busy      (msg_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      wr_done  <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= done_rd;
      if (done_rd) rd_data <= rsp_data;
      wr_done  <= done_wr;
      err      <= (req_fire && !req_good) || bad_rsp;
    end
  end

endmodule

// File: rtl/dma_xact_chk.sv
module dma_xact_chk #(
  parameter int AW = 32,
  parameter int LW = 8,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_kind,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_kind,
  input logic          net_valid,
  input logic          net_ready,
  input logic [1:0]    net_type,
  input logic [AW-1:0] net_paddr,
  input logic [LW-1:0] net_len,
  input logic [DW-1:0] net_data,
  input logic          rd_valid,
  input logic          wr_done,
  input logic          err,
  input logic [1:0]    cur_st
);

  assert_load_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_kind == 2'b01 |=> cur_st == 2'd1 && !req_ready);

  assert_store_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_kind == 2'b10 |=> cur_st == 2'd2 && !req_ready);

  assert_msg_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    net_valid && !net_ready |=> net_valid && $stable(net_type) && $stable(net_paddr)
                                && $stable(net_len) && $stable(net_data));

  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  assert_idle_no_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && cur_st == 2'd0 && (rsp_kind == 2'b01 || rsp_kind == 2'b10) |-> !rsp_ready);

  assert_bad_req_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_kind == 2'b00 || req_kind == 2'b11)
    |=> err && cur_st == 2'd0 && !net_valid);

endmodule

bind dma_xact_ctrl dma_xact_chk #(.AW(AW), .LW(LW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_kind  (rsp_kind),
  .net_valid (net_valid),
  .net_ready (net_ready),
  .net_type  (net_type),
  .net_paddr (net_paddr),
  .net_len   (net_len),
  .net_data  (net_data),
  .rd_valid  (rd_valid),
  .wr_done   (wr_done),
  .err       (err),
  .cur_st    (cur_st)
);

// File: tb/sim_dma_xact_ctrl.sv
module sim_dma_xact_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, LW = 8, DW = 64, DELAY = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, net_ready = 0, rsp_valid = 0;
  logic [1:0] req_kind = 0, rsp_kind = 0;
  logic [AW-1:0] req_paddr = 0;
  logic [LW-1:0] req_len = 0;
  logic [DW-1:0] req_data = 0, rsp_data = 0;
  logic req_ready, net_valid, rsp_ready, rd_valid, wr_done, err;
  logic [1:0] net_type, net_class;
  logic [AW-1:0] net_paddr;
  logic [LW-1:0] net_len;
  logic [DW-1:0] net_data, rd_data;

  dma_xact_ctrl #(.AW(AW), .LW(LW), .DW(DW), .DELAY(DELAY)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit stop = 0, done_flag = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st = 0;                       // 0 idle, 1 awaiting data, 2 awaiting ack
  bit m_pend = 0;
  int m_cd = 0;
  logic [1:0] m_type;
  logic [AW-1:0] m_paddr;
  logic [LW-1:0] m_len;
  logic [DW-1:0] m_data, e_rdd;
  bit e_rd = 0, e_wr = 0, e_err = 0;
  bit t_acc, t_racc;

  function automatic bit model_takes(int st, logic [1:0] k);
    case (k)
      2'b01:   return st == 1;
      2'b10:   return st == 2;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pend = 0; m_cd = 0; e_rd = 0; e_wr = 0; e_err = 0; e_rdd = 0;
    end else begin
      t_acc  = req_valid && m_st == 0 && !m_pend;
      t_racc = rsp_valid && model_takes(m_st, rsp_kind);
      e_rd = 0; e_wr = 0; e_err = 0;
      if (m_pend) begin
        if (m_cd > 0) m_cd--;
        else if (net_ready) m_pend = 0;
      end
      if (t_racc) begin
        if (rsp_kind == 2'b01) begin e_rd = 1; e_rdd = rsp_data; m_st = 0; end
        else if (rsp_kind == 2'b10) begin e_wr = 1; m_st = 0; end
        else e_err = 1;
      end
      if (t_acc) begin
        if (req_kind == 2'b01 || req_kind == 2'b10) begin
          m_st = (req_kind == 2'b01) ? 1 : 2;
          m_pend = 1; m_cd = DELAY;
          m_type = req_kind; m_paddr = req_paddr; m_len = req_len; m_data = req_data;
        end else e_err = 1;
      end
    end
  end

  // compare every cycle, a quarter period after the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      #(CLK_PERIOD/4);
      chk(req_ready == (m_st == 0 && !m_pend), "R7 req_ready", req_ready, m_st == 0 && !m_pend);
      chk(net_valid == (m_pend && m_cd == 0), "R5 net_valid", net_valid, m_pend && m_cd == 0);
      chk(net_class == 2'b01, "R4 net_class", net_class, 2'b01);
      if (net_valid && m_pend) begin
        chk(net_type == m_type, "R2/R3 net_type", net_type, m_type);
        chk(net_paddr == m_paddr && net_len == m_len, "R4 addr/len", {net_len, net_paddr}, {m_len, m_paddr});
        chk(net_data == m_data, "R4 data", net_data, m_data);
      end
      chk(rsp_ready == model_takes(m_st, rsp_kind), "R10 rsp_ready", rsp_ready, model_takes(m_st, rsp_kind));
      chk(rd_valid == e_rd, "R8 rd_valid", rd_valid, e_rd);
      if (e_rd) chk(rd_data == e_rdd, "R8 rd_data", rd_data, e_rdd);
      chk(wr_done == e_wr, "R9 wr_done", wr_done, e_wr);
      chk(err == e_err, "R11/R12 err", err, e_err);
    end
  end

  // ---------------- drivers ----------------
  task automatic put_req(logic [1:0] k);
    bit r;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_paddr = $urandom; req_len = LW'($urandom);
    req_data = {$urandom, $urandom};
    do begin
      #(CLK_PERIOD/4); r = req_ready;
      @(posedge clk); #1;
    end while (!r);
    req_valid = 0;
  endtask

  task automatic put_rsp(logic [1:0] k, int maxc);
    bit r;
    @(negedge clk);
    rsp_valid = 1; rsp_kind = k; rsp_data = {$urandom, $urandom};
    for (int i = 0; i < maxc; i++) begin
      #(CLK_PERIOD/4); r = rsp_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    rsp_valid = 0;
  endtask

  task automatic wait_net_and_send();
    while (!net_valid) begin @(posedge clk); #1; end
    @(negedge clk); net_ready = 1;
    @(negedge clk); net_ready = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int n;
    time t_ack, t_acc2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !net_valid && !rd_valid && !wr_done && !err, "R1 reset state",
        {req_ready, net_valid, rd_valid, wr_done, err}, 5'b10000);
    rst_n = 1;
    #1;
    chk(req_ready == 1 && net_valid == 0, "R1 after reset", {req_ready, net_valid}, 2'b10);

    // load with back-pressure, timed delay
    put_req(2'b01);
    chk(req_ready == 0, "R2 busy after load", req_ready, 0);
    n = 0;
    while (!net_valid && n < 20) begin @(posedge clk); #1; n++; end
    chk(n == DELAY, "R5 delay edges", n, DELAY);
    chk(net_type == 2'b01, "R2 read type", net_type, 2'b01);
    repeat (4) @(posedge clk);
    #1 chk(net_valid == 1, "R6 held under back-pressure", net_valid, 1);
    put_rsp(2'b10, 3);                  // wrong kind while awaiting data
    chk(req_ready == 0, "R10 state kept", req_ready, 0);
    @(negedge clk); net_ready = 1;
    @(negedge clk); net_ready = 0;
    #1 chk(net_valid == 0, "R6 removed on take", net_valid, 0);
    put_rsp(2'b11, 2);                  // illegal kind consumed
    chk(err == 1, "R12 err on bad response", err, 1);
    put_rsp(2'b01, 4);
    chk(rd_valid == 1, "R8 read strobe", rd_valid, 1);

    // store with a load stalled behind it
    put_req(2'b10);
    chk(req_ready == 0, "R3 busy after store", req_ready, 0);
    fork
      begin put_req(2'b01); t_acc2 = $time; end
      begin
        wait_net_and_send();
        put_rsp(2'b10, 4);
        t_ack = $time;
        chk(wr_done == 1, "R9 write strobe", wr_done, 1);
      end
    join
    chk(t_acc2 > t_ack, "R7 stalled request after completion", t_acc2, t_ack);
    wait_net_and_send();
    put_rsp(2'b01, 4);

    // illegal requests and idle responses
    put_req(2'b00);
    chk(err == 1 && req_ready == 1, "R11 code 00", {err, req_ready}, 2'b11);
    put_req(2'b11);
    chk(err == 1 && net_valid == 0, "R11 code 11", {err, net_valid}, 2'b10);
    put_rsp(2'b01, 2);
    chk(rsp_ready == 0 && rd_valid == 0, "R10 idle data ignored", {rsp_ready, rd_valid}, 0);

    // random phase
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          repeat ($urandom_range(0, 4)) @(negedge clk);
          put_req(2'($urandom));
        end
        stop = 1;
      end
      begin
        while (!stop) begin
          @(negedge clk);
          rsp_valid = ($urandom_range(0, 3) == 0);
          rsp_kind = 2'($urandom); rsp_data = {$urandom, $urandom};
        end
        rsp_valid = 0;
      end
      begin
        while (!stop) begin @(negedge clk); net_ready = $urandom_range(0, 1); end
      end
    join
    repeat (4) @(negedge clk);
    report();
  end

endmodule